// File: doc/BRIEF.md
# Multichannel Audio Serial Transmitter

This block turns parallel audio sample words into bit-serial streams on up to four data lanes. All lanes share one bit clock and one word-select line. Word select is low during the left slot and high during the right slot. The first bit of each word goes out one bit clock after the word-select change. The block works in one of two timing roles. As master, it divides the system clock down to a bit clock and drives both timing pins. As slave, it follows a bit clock and word select driven by an external converter; these are synchronised into the system clock domain. Bit order and the clock edge used for launching data are set by configuration inputs.

One handshake transfers a whole frame: the left and right sample of every lane. The transfer happens when the block sees word select enter a left slot. In stereo mode each lane sends its own left and right words. In mono mode each lane sends its left word in both slots. A two-bit lane count picks how many lanes carry audio; the other lanes send zeros. Configuration is static while transmission is enabled.

Top module: `aud_serializer`

## Requirements
- R1: While `tx_en` is low, every `sd` lane and `s_ready` stay 0, `sck_o` rests at 0 and `ws_o` rests at 1. Enabling again restarts the bit-clock generator and the frame from the beginning.
- R2: In master mode (`cfg_master`=1), `sck_oe` and `ws_oe` are 1. `sck_o` toggles every `cfg_div`+1 system clocks. `ws_o` is 0 for W bit clocks (left slot) and then 1 for W bit clocks (right slot).
- R3: In slave mode (`cfg_master`=0), `sck_oe` and `ws_oe` are 0 and timing follows `sck_i`/`ws_i`. Slots may be longer than W bits; the bits after the W sample bits are 0.
- R4: The first bit of a word is launched on the first launch edge after the capture edge on which word select is seen to change. The following W-1 bits are launched on the following launch edges.
- R5: With `cfg_lsb_first`=0, each word is sent MSB first. With `cfg_lsb_first`=1, it is sent LSB first.
- R6: With `cfg_edge`=0, word select is sampled on the rising bit-clock edge and data changes on the falling edge. With `cfg_edge`=1, the two edges are swapped.
- R7: Lane i carries audio only when i <= `cfg_lanes` (0: lane 0 only, 3: all four lanes). Every other lane sends zero words.
- R8: In slave mode only lane 0 carries audio, whatever the value of `cfg_lanes`; lanes 1 to 3 send zeros.
- R9: With `cfg_mono`=1, each active lane sends its left sample in both the left and the right slot.
- R10: `s_ready` is high for exactly one system clock per frame: the clock in which the capture edge sees word select go from 1 to 0. The frame is taken when `s_ready` is high. In `s_data`, lane i's left word sits at bits [2iW +: W] and its right word at bits [(2i+1)W +: W].
- R11: If `s_valid` is low while `s_ready` is high, every lane sends zero words for that frame.
- R12: `cfg_master` is changed only while `tx_en` is low. The new role takes effect on the pin enables at once, and on timing at the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmission enable |
| cfg_master | input | 1 | 1: block drives bit clock and word select |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_edge | input | 1 | 0: capture on rising, launch on falling; 1: swapped |
| cfg_mono | input | 1 | 1: left word repeated in right slot |
| cfg_lanes | input | $clog2(LANES) | Highest active lane index |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| s_data | input | 2*LANES*W | One frame of samples |
| s_valid | input | 1 | Frame available |
| s_ready | output | 1 | Frame taken this clock |
| sck_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word select (slave) |
| sck_o | output | 1 | Generated bit clock (master) |
| ws_o | output | 1 | Generated word select (master) |
| sck_oe | output | 1 | Bit-clock pin drive enable |
| ws_oe | output | 1 | Word-select pin drive enable |
| sd | output | LANES | Serial data, one bit per lane |

## Verification
The bench builds the block with W=8, LANES=4 and DIV_W=4. The 16-bit frame keeps every run to a few hundred clocks per frame. Four lanes make every lane-count code and the zero-filled lanes observable. A divider of 0 gives the tightest case, where capture and launch fall on back-to-back clocks. The slave runs use slots two bits longer than a word, so the zero padding and the synchroniser latency against a slow external bit clock are both covered.

// File: rtl/aud_ser_pkg.sv
// Package: shared types for the audio serial transmitter.
// Assumes a single system clock domain; bit-clock edges are carried as
// one-cycle event flags rather than as clocks.
package aud_ser_pkg;

    // Slot selector: word select low is the left slot.
    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    // Bit-clock timing events seen in the system clock domain.
    typedef struct packed {
        logic launch;   // data may change in this cycle's update
        logic capture;  // word select is sampled in this cycle
        logic ws;       // word-select level valid at capture
    } bit_evt_t;

endpackage

// File: rtl/aud_clkgen.sv
// Module: master-mode timing generator.
// Divides clk into a bit clock with half period cfg_div+1 cycles and derives
// word select from a bit counter over a 2*W bit frame. Word select changes
// on launch edges. Held at idle (sck 0, ws 1) while run is low.
module aud_clkgen
    import aud_ser_pkg::*;
#(
    parameter int W     = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_edge,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             sck,
    output logic             ws,
    output bit_evt_t         evt
);

    localparam int FRAME_BITS = 2 * W;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] HALF_BIT = CW'(W);

    logic [DIV_W-1:0] div_cnt;
    logic [CW-1:0]    bit_cnt;
    logic [CW-1:0]    bit_nxt;
    logic             sck_q;
    logic             ws_q;
    logic             toggle;
    logic             rise;
    logic             fall;
    logic             launch;
    logic             capture;

    // Edge detection of the divider and the launch/capture mapping.
    always_comb begin
        toggle  = run && (div_cnt == cfg_div);
        rise    = toggle && !sck_q;
        fall    = toggle && sck_q;
        launch  = cfg_edge ? rise : fall;
        capture = cfg_edge ? fall : rise;
        bit_nxt = (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
    end

    // Divider, bit clock level, frame bit counter and word select.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            sck_q   <= 1'b0;
            ws_q    <= 1'b1;
            bit_cnt <= LAST_BIT;
        end else begin
            div_cnt <= toggle ? '0 : div_cnt + 1'b1;
            if (toggle) begin
                sck_q <= ~sck_q;
            end
            if (launch) begin
                bit_cnt <= bit_nxt;
                ws_q    <= (bit_nxt >= HALF_BIT);
            end
        end
    end

    // Output mapping.
    always_comb begin
        sck         = sck_q;
        ws          = ws_q;
        evt.launch  = launch;
        evt.capture = capture;
        evt.ws      = ws_q;
    end

endmodule

// File: rtl/aud_slave_sync.sv
// Module: slave-mode timing follower.
// Brings external bit clock and word select into clk through two flops each
// and turns bit-clock transitions into launch/capture events. Assumes each
// external half period lasts well over three system clocks.
module aud_slave_sync
    import aud_ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run,
    input  logic     cfg_edge,
    input  logic     sck_i,
    input  logic     ws_i,
    output bit_evt_t evt
);

    logic [2:0] sck_sh;
    logic [1:0] ws_sh;
    logic       rise;
    logic       fall;

    // Synchroniser chains; they keep running so enabling causes no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh <= '0;
            ws_sh  <= 2'b11;
        end else begin
            sck_sh <= {sck_sh[1:0], sck_i};
            ws_sh  <= {ws_sh[0], ws_i};
        end
    end

    // Edge detection and the launch/capture mapping.
    always_comb begin
        rise        = run && sck_sh[1] && !sck_sh[2];
        fall        = run && !sck_sh[1] && sck_sh[2];
        evt.launch  = cfg_edge ? rise : fall;
        evt.capture = cfg_edge ? fall : rise;
        evt.ws      = ws_sh[1];
    end

endmodule

// File: rtl/aud_lane.sv
// Module: one serial data lane.
// Loads a word on a launch event flagged as start and shifts it out one bit
// per launch event, MSB or LSB first; sends 0 once the word is exhausted.
module aud_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         launch,
    input  logic         start,
    input  logic         lsb_first,
    input  logic [W-1:0] word,
    output logic         sd
);

    localparam int RW = $clog2(W);

    logic [W-1:0]  sr;
    logic [RW-1:0] remain;
    logic          sd_q;

    // Shift register: load on start, shift on launch, zero after the word.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sr     <= '0;
            remain <= '0;
            sd_q   <= 1'b0;
        end else if (launch) begin
            if (start) begin
                sd_q   <= lsb_first ? word[0] : word[W-1];
                sr     <= lsb_first ? (word >> 1) : (word << 1);
                remain <= RW'(W - 1);
            end else if (remain != '0) begin
                sd_q   <= lsb_first ? sr[0] : sr[W-1];
                sr     <= lsb_first ? (sr >> 1) : (sr << 1);
                remain <= remain - 1'b1;
            end else begin
                sd_q   <= 1'b0;
            end
        end
    end

    assign sd = sd_q;

endmodule

// File: rtl/aud_serializer.sv
// Module: multichannel audio serial transmitter (top).
// Picks master or slave timing, detects word-select changes at capture
// events, fetches one frame per left slot and drives LANES serial outputs.
// Assumes configuration changes only while tx_en is low.
module aud_serializer
    import aud_ser_pkg::*;
#(
    parameter int W     = 16,
    parameter int LANES = 4,
    parameter int DIV_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_en,
    input  logic                       cfg_master,
    input  logic                       cfg_lsb_first,
    input  logic                       cfg_edge,
    input  logic                       cfg_mono,
    input  logic [$clog2(LANES)-1:0]   cfg_lanes,
    input  logic [DIV_W-1:0]           cfg_div,
    input  logic [2*LANES*W-1:0]       s_data,
    input  logic                       s_valid,
    output logic                       s_ready,
    input  logic                       sck_i,
    input  logic                       ws_i,
    output logic                       sck_o,
    output logic                       ws_o,
    output logic                       sck_oe,
    output logic                       ws_oe,
    output logic [LANES-1:0]           sd
);

    localparam int LW = $clog2(LANES);
    localparam int FW = 2 * LANES * W;

    bit_evt_t    gen_evt;
    bit_evt_t    slv_evt;
    bit_evt_t    evt;
    logic        ws_prev;
    logic        pend;
    slot_e       slot;
    logic [FW-1:0] frame_q;
    logic        take_left;
    logic        take_right;
    logic        start;

    // Master timing generator.
    aud_clkgen #(
        .W     (W),
        .DIV_W (DIV_W)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tx_en && cfg_master),
        .cfg_edge (cfg_edge),
        .cfg_div  (cfg_div),
        .sck      (sck_o),
        .ws       (ws_o),
        .evt      (gen_evt)
    );

    // Slave timing follower.
    aud_slave_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tx_en && !cfg_master),
        .cfg_edge (cfg_edge),
        .sck_i    (sck_i),
        .ws_i     (ws_i),
        .evt      (slv_evt)
    );

    // Timing source selection and slot-change detection.
    always_comb begin
        evt        = cfg_master ? gen_evt : slv_evt;
        take_left  = tx_en && evt.capture && !evt.ws && ws_prev;
        take_right = tx_en && evt.capture && evt.ws && !ws_prev;
        start      = pend && evt.launch;
        s_ready    = take_left;
        sck_oe     = cfg_master;
        ws_oe      = cfg_master;
    end

    // Frame fetch, pending-load flag and current slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            ws_prev <= 1'b1;
            pend    <= 1'b0;
            slot    <= SLOT_LEFT;
            frame_q <= '0;
        end else begin
            if (evt.capture) begin
                ws_prev <= evt.ws;
            end
            if (take_left) begin
                frame_q <= s_valid ? s_data : '0;
                pend    <= 1'b1;
                slot    <= SLOT_LEFT;
            end else if (take_right) begin
                pend    <= 1'b1;
                slot    <= SLOT_RIGHT;
            end else if (evt.launch) begin
                pend    <= 1'b0;
            end
        end
    end

    // Per-lane word selection and serialiser.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] left_w;
        logic [W-1:0] right_w;
        logic [W-1:0] word;
        logic         active;

        // Choose the word for this lane and slot; zero when inactive.
        always_comb begin
            left_w  = frame_q[(2*i)*W +: W];
            right_w = cfg_mono ? left_w : frame_q[(2*i+1)*W +: W];
            active  = (i == 0) ||
                      (cfg_master && ((LW+1)'(i) <= {1'b0, cfg_lanes}));
            word    = !active ? '0 : ((slot == SLOT_RIGHT) ? right_w : left_w);
        end

        aud_lane #(
            .W (W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (tx_en),
            .launch    (evt.launch),
            .start     (start),
            .lsb_first (cfg_lsb_first),
            .word      (word),
            .sd        (sd[i])
        );
    end

endmodule

// File: rtl/aud_serializer_chk.sv
// Module: property checker for aud_serializer, attached by bind.
// Observes ports only; relies on configuration being static while enabled.
module aud_serializer_chk #(
    parameter int W     = 16,
    parameter int LANES = 4,
    parameter int DIV_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tx_en,
    input logic                     cfg_master,
    input logic                     cfg_edge,
    input logic [$clog2(LANES)-1:0] cfg_lanes,
    input logic                     s_ready,
    input logic                     sck_o,
    input logic                     ws_o,
    input logic [LANES-1:0]         sd
);

    localparam int LW = $clog2(LANES);

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> (sd == '0) && !s_ready && !sck_o && ws_o); // R1

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) s_ready |=> !s_ready); // R10

    AST_WS_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && $past(tx_en) && cfg_master && !$stable(ws_o)) |-> (!$stable(sck_o) && (sck_o == cfg_edge))); // R6

    AST_SD_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && $past(tx_en) && cfg_master && !$stable(sd)) |-> (!$stable(sck_o) && (sck_o == cfg_edge))); // R6

    AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && $past(tx_en)) |-> $stable(cfg_master)); // R12

    for (genvar i = 1; i < LANES; i++) begin : g_zero
        AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tx_en && $past(tx_en) && $stable(cfg_lanes) && $stable(cfg_master) && !(cfg_master && ((LW+1)'(i) <= {1'b0, cfg_lanes}))) |-> !sd[i]); // R7
    end

endmodule

bind aud_serializer aud_serializer_chk #(
    .W     (W),
    .LANES (LANES),
    .DIV_W (DIV_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .cfg_master (cfg_master),
    .cfg_edge   (cfg_edge),
    .cfg_lanes  (cfg_lanes),
    .s_ready    (s_ready),
    .sck_o      (sck_o),
    .ws_o       (ws_o),
    .sd         (sd)
);

// File: tb/sim_aud_serializer.sv
`timescale 1ns/1ps
// Bench: behavioural receiver model compared every clock against the pins.
module sim_aud_serializer;

    localparam int W     = 8;
    localparam int LANES = 4;
    localparam int DIV_W = 4;
    localparam int FW    = 2 * LANES * W;
    localparam int SLV_HALF = 8;
    localparam int SLV_SLOT = W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tx_en = 1'b0;
    logic             cfg_master = 1'b1;
    logic             cfg_lsb_first = 1'b0;
    logic             cfg_edge = 1'b0;
    logic             cfg_mono = 1'b0;
    logic [1:0]       cfg_lanes = 2'd0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [FW-1:0]    s_data;
    logic             s_valid = 1'b1;
    logic             s_ready;
    logic             sck_i = 1'b0;
    logic             ws_i = 1'b1;
    logic             sck_o, ws_o, sck_oe, ws_oe;
    logic [LANES-1:0] sd;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    aud_serializer #(.W(W), .LANES(LANES), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_master(cfg_master),
        .cfg_lsb_first(cfg_lsb_first), .cfg_edge(cfg_edge), .cfg_mono(cfg_mono),
        .cfg_lanes(cfg_lanes), .cfg_div(cfg_div), .s_data(s_data),
        .s_valid(s_valid), .s_ready(s_ready), .sck_i(sck_i), .ws_i(ws_i),
        .sck_o(sck_o), .ws_o(ws_o), .sck_oe(sck_oe), .ws_oe(ws_oe), .sd(sd)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [FW-1:0] make_frame(input int k);
        logic [FW-1:0] f;
        for (int m = 0; m < 2*LANES; m++) f[m*W +: W] = W'((k*37 + m*53 + 11) ^ (m << 4));
        return f;
    endfunction

    function automatic logic [W-1:0] exp_word(input logic [FW-1:0] f, input int lane, input bit right);
        logic [W-1:0] l;
        bit act;
        act = (lane == 0) || (cfg_master && lane <= int'(cfg_lanes));
        l = f[(2*lane)*W +: W];
        if (!act) return '0;
        if (!right || cfg_mono) return l;
        return f[(2*lane+1)*W +: W];
    endfunction

    // Receiver and frame-feed state.
    logic [FW-1:0] fq[$];
    logic [FW-1:0] cur;
    logic [FW-1:0] zero_f = '0;
    bit  have_cur, collecting, slot_r, ws_last, sck_last, adv, rdy_last;
    bit  sck_seen, sck_prev_m;
    int  bitidx, pat, cyc_since;
    logic [W-1:0] acc [LANES];

    // Word-level comparison with the requirement the case belongs to.
    task automatic compare_words();
        string tag;
        bit under;
        logic [W-1:0] e;
        under = (cur == zero_f);
        for (int ln = 0; ln < LANES; ln++) begin
            e = exp_word(cur, ln, slot_r);
            if (!((ln == 0) || (cfg_master && ln <= int'(cfg_lanes)))) tag = cfg_master ? "R7" : "R8";
            else if (under) tag = "R11";
            else if (slot_r && cfg_mono) tag = "R9";
            else if (cfg_lsb_first) tag = "R5";
            else if (cfg_edge) tag = "R6";
            else if (slot_r) tag = "R10";
            else tag = "R4";
            check(acc[ln] == e, tag, acc[ln], e);
        end
    endtask

    // Every clock: feed frames, check the bit-clock period, deserialise and compare.
    always @(negedge clk) begin
        logic sck_now, ws_now;
        if (!rst_n) begin
            pat = 0; s_data = make_frame(0); adv = 0; rdy_last = 0;
        end else begin
            if (adv) begin pat++; s_data = make_frame(pat); adv = 0; end
            if (s_ready) begin
                check(!rdy_last, "R10", rdy_last, 0);
                fq.push_back(s_valid ? s_data : zero_f);
                adv = 1;
            end
            rdy_last = s_ready;
        end
        sck_now = cfg_master ? sck_o : sck_i;
        ws_now  = cfg_master ? ws_o : ws_i;
        if (!tx_en || !rst_n) begin
            fq.delete(); have_cur = 0; collecting = 0; ws_last = 1; bitidx = 0;
            sck_seen = 0; cyc_since = 0;
        end else begin
            if (cfg_master) begin
                cyc_since++;
                if (sck_o != sck_prev_m) begin
                    if (sck_seen) check(cyc_since == int'(cfg_div) + 1, "R2", cyc_since, int'(cfg_div) + 1);
                    sck_seen = 1; cyc_since = 0;
                end
            end
            if ((sck_now != sck_last) && (sck_now == !cfg_edge)) begin
                if (collecting) begin
                    if (bitidx < W) begin
                        for (int ln = 0; ln < LANES; ln++) begin
                            if (cfg_lsb_first) acc[ln][bitidx] = sd[ln];
                            else acc[ln][W-1-bitidx] = sd[ln];
                        end
                        bitidx++;
                        if (bitidx == W) begin
                            if (!slot_r) begin
                                if (fq.size() == 0) check(0, "R10", 0, 1);
                                else begin cur = fq.pop_front(); have_cur = 1; compare_words(); end
                            end else if (have_cur) compare_words();
                        end
                    end else begin
                        check(sd == '0, "R3", sd, 0);
                        bitidx++;
                    end
                end
                if (ws_now != ws_last) begin
                    collecting = 1; slot_r = ws_now; bitidx = 0;
                end
                ws_last = ws_now;
            end
        end
        sck_last = sck_now;
        sck_prev_m = sck_o;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic idle_check();
        tx_en = 0;
        tick(3);
        @(negedge clk);
        check(sd == '0, "R1", sd, 0);
        check(!s_ready && !sck_o && ws_o, "R1", {s_ready, sck_o, ws_o}, 3'b001);
        tick(1);
    endtask

    task automatic run_master(input bit lsb, input bit edge_sel, input bit mono,
                              input int lanes, input int div, input int frames);
        cfg_master = 1; cfg_lsb_first = lsb; cfg_edge = edge_sel; cfg_mono = mono;
        cfg_lanes = 2'(lanes); cfg_div = DIV_W'(div);
        tick(1);
        @(negedge clk);
        check(sck_oe && ws_oe, "R12", {sck_oe, ws_oe}, 2'b11);
        tick(1);
        tx_en = 1;
        tick(frames * 2 * W * 2 * (div + 1) + 8);
        idle_check();
    endtask

    task automatic run_slave(input bit lsb, input bit edge_sel, input bit mono,
                             input int lanes, input int frames);
        bit ll;
        cfg_master = 0; cfg_lsb_first = lsb; cfg_edge = edge_sel; cfg_mono = mono;
        cfg_lanes = 2'(lanes);
        ll = edge_sel;
        sck_i = ll; ws_i = 1;
        tick(6);
        @(negedge clk);
        check(!sck_oe && !ws_oe, "R12", {sck_oe, ws_oe}, 0);
        check(!sck_oe && !ws_oe, "R3", {sck_oe, ws_oe}, 0);
        tick(1);
        tx_en = 1;
        tick(4);
        for (int f = 0; f < frames; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int j = 0; j < SLV_SLOT; j++) begin
                    sck_i = ~ll;
                    tick(SLV_HALF);
                    sck_i = ll;
                    if (j == 0) ws_i = s[0];
                    tick(SLV_HALF);
                end
            end
        end
        sck_i = ~ll;
        tick(SLV_HALF);
        idle_check();
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        tick(4);
        @(negedge clk);
        check(sd == '0 && !s_ready, "R1", {sd, s_ready}, 0);
        tick(1);
        rst_n = 1;
        tick(2);
        @(negedge clk);
        check(!sck_o && ws_o && (sd == '0), "R1", {sck_o, ws_o, sd}, 6'b010000);
        tick(1);
        run_master(0, 0, 0, 3, 1, 6);
        run_master(1, 1, 1, 1, 0, 6);
        run_master(0, 1, 0, 0, 2, 4);
        run_slave(0, 0, 0, 3, 4);
        run_slave(1, 1, 1, 2, 3);
        s_valid = 0;
        run_master(0, 0, 0, 3, 1, 3);
        s_valid = 1;
        finish_up();
    end

endmodule